// File: doc/BRIEF.md
# Self-Setting BCD Clock with View Selector and Alarm

This block keeps the time of day as packed BCD hours, minutes and seconds and holds a BCD date (day, month, year). When an upstream time-code decoder reports that a complete, checked frame is available, the next received seconds strobe presets the time and date from the decoded fields. Between presets, while the receiver is locked, the clock advances once per received seconds strobe. When lock drops, the clock advances from its own one-second tick, made by dividing a 50 Hz mains reference by 50.

Six shared digit outputs present one of three views: time, date or alarm. A debounced push button steps a one-hot ring through the views. The digit outputs come with a per-digit blank mask for leading-zero suppression. An alarm time is stepped by two debounced buttons while the alarm view is shown. A latch arms when hours and minutes both match the alarm setting and disarms when only the minutes match, so the alarm lasts one hour. While the latch is set, the alarm output carries an audio square wave that is switched on and off several times a second.

Top module: `selfset_clock`

## Requirements
- R1: When `sec_strobe` is high and `data_valid` is high in the same cycle, hours and minutes load from `load_hour`/`load_min`, seconds load 00, and day, month and year load from their inputs. This applies whether or not the clock is locked.
- R2: Each advance steps the seconds in BCD: the units go 9 to 0 with a carry into the tens, and 59 goes to 00 with a carry into the minutes.
- R3: Minutes go 59 to 00 with a carry into the hours, and the hours go 23 to 00, all in packed BCD. After reset the time reads 00:00:00.
- R4: While `locked` is high, a `sec_strobe` with `data_valid` low advances the time by one second, and `mains_tick` pulses have no effect.
- R5: While `locked` is low, every 50th `mains_tick` pulse advances the time by one second, and a `sec_strobe` with `data_valid` low has no effect.
- R6: `view` is one-hot with bit0 for time, bit1 for date and bit2 for alarm. It resets to 3'b001, and each accepted press of `btn_view` rotates it 001 to 010 to 100 to 001.
- R7: A button level that holds for fewer than DEBOUNCE_CYCLES clocks is ignored. A level that holds for longer is accepted as one press on its rising edge.
- R8: `digits` carries six BCD nibbles, with digit 5 at bits [23:20] and digit 0 at bits [3:0]. Time view shows HHMMSS, date view shows DDMMYY, and alarm view shows the alarm HHMM on digits 5 to 2 with digits 1 and 0 blanked (value 0).
- R9: `blank` bit k suppresses digit k. Digit 5 is blanked when it is 0 in the time and alarm views. In the date view digit 3 (tens of months) is blanked when it is 0 and digit 5 is shown. No other digit is blanked by a zero value.
- R10: The alarm setting resets to 06:30. An accepted `btn_slow` press steps the alarm minutes (59 to 00, hours unchanged), and an accepted `btn_fast` press steps the alarm hours (23 to 00). Both are ignored unless the alarm view is selected.
- R11: `alarm_on` sets when the time's hours and minutes both equal the alarm setting. It clears when the minutes equal the alarm minutes but the hours differ, and otherwise holds.
- R12: While `alarm_on` is 0, `alarm_out` is 0. While it is 1, `alarm_out` is a square wave with half-period TONE_HALF clocks, gated by a slower on/off pattern with half-period BEEP_HALF clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| locked | input | 1 | Receiver lock; low selects the mains-derived tick |
| data_valid | input | 1 | Decoded time and date fields are valid for preset |
| sec_strobe | input | 1 | One-cycle pulse per received second |
| mains_tick | input | 1 | One-cycle pulse per 50 Hz mains cycle |
| load_hour | input | 8 | Decoded hours, packed BCD |
| load_min | input | 8 | Decoded minutes, packed BCD |
| load_day | input | 8 | Decoded day of month, packed BCD |
| load_month | input | 8 | Decoded month, packed BCD |
| load_year | input | 8 | Decoded year, packed BCD |
| btn_view | input | 1 | Raw view-select button |
| btn_slow | input | 1 | Raw alarm-minute step button |
| btn_fast | input | 1 | Raw alarm-hour step button |
| view | output | 3 | One-hot view selector |
| digits | output | 24 | Six BCD digits, digit 5 most significant |
| blank | output | 6 | Per-digit blank mask |
| alarm_on | output | 1 | Alarm latch state |
| alarm_out | output | 1 | Gated audio tone |

## Verification
The bench drives the carries at 23:59:59. A design that mishandled them would show 24:00:00 or 23:60:00, or would leave a stale tens digit. It counts mains ticks to exactly 49 and then 50, so an off-by-one divider shows up. It also checks that a strobe is ignored while unlocked and that mains ticks are ignored while locked, catching a clock that runs from both sources. A short button blip, and alarm buttons pressed outside the alarm view, must leave the view and the setting unchanged. The date view must blank the zero tens of months but not the zero tens of days. The alarm latch is driven through set, hold and minute-only clear, so a latch that clears on any mismatch, or never clears, is caught.

// File: rtl/clk_pkg.sv
package clk_pkg;
  localparam logic [2:0] VIEW_TIME  = 3'b001;
  localparam logic [2:0] VIEW_DATE  = 3'b010;
  localparam logic [2:0] VIEW_ALARM = 3'b100;

  localparam logic [7:0] ALARM_HOUR_RST = 8'h06;
  localparam logic [7:0] ALARM_MIN_RST  = 8'h30;

  typedef logic [7:0] bcd8_t;

  // Next value of a two-digit BCD counter that wraps to 00 after 'last'.
  function automatic bcd8_t bcd_step(input bcd8_t v, input bcd8_t last);
    bcd8_t r;
    if (v == last) r = 8'h00;
    else if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction
endpackage

// File: rtl/key_debounce.sv
module key_debounce #(
  parameter int HOLD_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic press
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [1:0]    sync_q;
  logic          stable_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= 2'b00;
      stable_q <= 1'b0;
      cnt_q    <= '0;
      press    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      press  <= 1'b0;
      if (sync_q[1] == stable_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q    <= '0;
        stable_q <= sync_q[1];
        press    <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R7: a press pulse only follows a level that stayed high through the count
  assert_press_level_R7: assert property (@(posedge clk) disable iff (rst)
    press |-> stable_q);
endmodule

// File: rtl/timekeeper.sv
module timekeeper
  import clk_pkg::*;
#(
  parameter int MAINS_DIV = 50
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  locked,
  input  logic  data_valid,
  input  logic  sec_strobe,
  input  logic  mains_tick,
  input  bcd8_t load_hour,
  input  bcd8_t load_min,
  input  bcd8_t load_day,
  input  bcd8_t load_month,
  input  bcd8_t load_year,
  output bcd8_t hour,
  output bcd8_t min,
  output bcd8_t sec,
  output bcd8_t day,
  output bcd8_t month,
  output bcd8_t year
);
  localparam int DW = (MAINS_DIV > 1) ? $clog2(MAINS_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(MAINS_DIV - 1);

  logic [DW-1:0] mdiv_q;
  logic load, mains_sec, adv;

  always_comb begin
    load      = sec_strobe && data_valid;
    mains_sec = !locked && mains_tick && (mdiv_q == DIV_LAST);
    adv       = !load && (locked ? sec_strobe : mains_sec);
  end

  always_ff @(posedge clk) begin
    if (rst || locked) mdiv_q <= '0;
    else if (mains_tick) mdiv_q <= (mdiv_q == DIV_LAST) ? '0 : mdiv_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hour  <= 8'h00;
      min   <= 8'h00;
      sec   <= 8'h00;
      day   <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
    end else if (load) begin
      hour  <= load_hour;
      min   <= load_min;
      sec   <= 8'h00;
      day   <= load_day;
      month <= load_month;
      year  <= load_year;
    end else if (adv) begin
      sec <= bcd_step(sec, 8'h59);
      if (sec == 8'h59) begin
        min <= bcd_step(min, 8'h59);
        if (min == 8'h59) hour <= bcd_step(hour, 8'h23);
      end
    end
  end

  // R1: preset lands on the next edge with seconds cleared
  assert_preset_R1: assert property (@(posedge clk) disable iff (rst)
    (sec_strobe && data_valid) |=> (sec == 8'h00 && hour == $past(load_hour)
                                    && min == $past(load_min)));
  // R5: unlocked with no mains tick and no preset, time holds
  assert_hold_unlocked_R5: assert property (@(posedge clk) disable iff (rst)
    (!locked && !mains_tick && !data_valid) |=> $stable({hour, min, sec}));
  // R4: locked with no strobe, time holds whatever the mains input does
  assert_hold_locked_R4: assert property (@(posedge clk) disable iff (rst)
    (locked && !sec_strobe) |=> $stable({hour, min, sec}));
  // R2: seconds stay legal BCD
  assert_sec_range_R2: assert property (@(posedge clk) disable iff (rst)
    (sec[3:0] <= 4'd9 && sec[7:4] <= 4'd5));
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import clk_pkg::*;
#(
  parameter int TONE_HALF = 250,
  parameter int BEEP_HALF = 40000
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  in_alarm_view,
  input  logic  slow_press,
  input  logic  fast_press,
  input  bcd8_t hour,
  input  bcd8_t min,
  output bcd8_t al_hour,
  output bcd8_t al_min,
  output logic  alarm_on,
  output logic  alarm_out
);
  localparam int TW = $clog2(TONE_HALF + 1);
  localparam int BW = $clog2(BEEP_HALF + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TONE_HALF - 1);
  localparam logic [BW-1:0] B_LAST = BW'(BEEP_HALF - 1);

  logic [TW-1:0] tcnt_q;
  logic [BW-1:0] bcnt_q;
  logic tone_q, gate_q;
  logic full_match, min_only;

  always_comb begin
    full_match = (hour == al_hour) && (min == al_min);
    min_only   = (min == al_min) && (hour != al_hour);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      al_hour <= ALARM_HOUR_RST;
      al_min  <= ALARM_MIN_RST;
    end else if (in_alarm_view) begin
      if (slow_press) al_min  <= bcd_step(al_min, 8'h59);
      if (fast_press) al_hour <= bcd_step(al_hour, 8'h23);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) alarm_on <= 1'b0;
    else if (full_match) alarm_on <= 1'b1;
    else if (min_only) alarm_on <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt_q <= '0; bcnt_q <= '0;
      tone_q <= 1'b0; gate_q <= 1'b0;
      alarm_out <= 1'b0;
    end else begin
      if (tcnt_q == T_LAST) begin tcnt_q <= '0; tone_q <= ~tone_q; end
      else tcnt_q <= tcnt_q + 1'b1;
      if (bcnt_q == B_LAST) begin bcnt_q <= '0; gate_q <= ~gate_q; end
      else bcnt_q <= bcnt_q + 1'b1;
      alarm_out <= alarm_on && gate_q && tone_q;
    end
  end

  // R12: no tone unless the latch was set the cycle before
  assert_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !alarm_on |=> !alarm_out);
  // R11: a full match always leaves the latch set
  assert_arm_R11: assert property (@(posedge clk) disable iff (rst)
    (hour == al_hour && min == al_min) |=> alarm_on);
  // R10: the setting never changes outside the alarm view
  assert_set_locked_R10: assert property (@(posedge clk) disable iff (rst)
    !in_alarm_view |=> $stable({al_hour, al_min}));
endmodule

// File: rtl/display_select.sv
module display_select
  import clk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  input  bcd8_t       hour,
  input  bcd8_t       min,
  input  bcd8_t       sec,
  input  bcd8_t       day,
  input  bcd8_t       month,
  input  bcd8_t       year,
  input  bcd8_t       al_hour,
  input  bcd8_t       al_min,
  output logic [2:0]  view,
  output logic [23:0] digits,
  output logic [5:0]  blank
);
  logic [23:0] dig_n;
  logic [5:0]  blk_n;

  always_ff @(posedge clk) begin
    if (rst) view <= VIEW_TIME;
    else if (step) view <= {view[1:0], view[2]};
  end

  // Exactly one view drives the shared digits.
  always_comb begin
    dig_n = {hour, min, sec};
    blk_n = 6'b000000;
    unique case (1'b1)
      view[1]: begin
        dig_n = {day, month, year};
        blk_n[3] = (month[7:4] == 4'd0);
      end
      view[2]: begin
        dig_n = {al_hour, al_min, 8'h00};
        blk_n[5] = (al_hour[7:4] == 4'd0);
        blk_n[1:0] = 2'b11;
      end
      default: begin
        blk_n[5] = (hour[7:4] == 4'd0);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      digits <= 24'h000000;
      blank  <= 6'b100000;
    end else begin
      digits <= dig_n;
      blank  <= blk_n;
    end
  end

  // R6: the selector ring never loses or duplicates its token
  assert_one_view_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(view) == 1);
  // R6: a step moves the token to the next position
  assert_rotate_R6: assert property (@(posedge clk) disable iff (rst)
    step |=> view == {$past(view[1:0]), $past(view[2])});
endmodule

// File: rtl/selfset_clock.sv
module selfset_clock
  import clk_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 20000,
  parameter int MAINS_DIV       = 50,
  parameter int TONE_HALF       = 250,
  parameter int BEEP_HALF       = 40000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        locked,
  input  logic        data_valid,
  input  logic        sec_strobe,
  input  logic        mains_tick,
  input  logic [7:0]  load_hour,
  input  logic [7:0]  load_min,
  input  logic [7:0]  load_day,
  input  logic [7:0]  load_month,
  input  logic [7:0]  load_year,
  input  logic        btn_view,
  input  logic        btn_slow,
  input  logic        btn_fast,
  output logic [2:0]  view,
  output logic [23:0] digits,
  output logic [5:0]  blank,
  output logic        alarm_on,
  output logic        alarm_out
);
  localparam int NKEYS = 3;

  logic [NKEYS-1:0] raw_keys, presses;
  bcd8_t hour, min, sec, day, month, year, al_hour, al_min;

  assign raw_keys = {btn_fast, btn_slow, btn_view};

  for (genvar k = 0; k < NKEYS; k++) begin : g_keys
    key_debounce #(.HOLD_CYCLES(DEBOUNCE_CYCLES)) u_deb (
      .clk(clk), .rst(rst), .raw(raw_keys[k]), .press(presses[k]));
  end

  timekeeper #(.MAINS_DIV(MAINS_DIV)) u_time (
    .clk(clk), .rst(rst), .locked(locked), .data_valid(data_valid),
    .sec_strobe(sec_strobe), .mains_tick(mains_tick),
    .load_hour(load_hour), .load_min(load_min), .load_day(load_day),
    .load_month(load_month), .load_year(load_year),
    .hour(hour), .min(min), .sec(sec), .day(day), .month(month), .year(year));

  alarm_unit #(.TONE_HALF(TONE_HALF), .BEEP_HALF(BEEP_HALF)) u_alarm (
    .clk(clk), .rst(rst), .in_alarm_view(view[2]),
    .slow_press(presses[1]), .fast_press(presses[2]),
    .hour(hour), .min(min), .al_hour(al_hour), .al_min(al_min),
    .alarm_on(alarm_on), .alarm_out(alarm_out));

  display_select u_disp (
    .clk(clk), .rst(rst), .step(presses[0]),
    .hour(hour), .min(min), .sec(sec), .day(day), .month(month), .year(year),
    .al_hour(al_hour), .al_min(al_min),
    .view(view), .digits(digits), .blank(blank));

  // R3: hours never leave 00..23
  assert_hour_range_R3: assert property (@(posedge clk) disable iff (rst)
    (hour <= 8'h23 && hour[3:0] <= 4'd9));
endmodule

// File: tb/selfset_clock_test.sv
module selfset_clock_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic locked = 1'b0, data_valid = 1'b0, sec_strobe = 1'b0, mains_tick = 1'b0;
  logic [7:0] load_hour = 0, load_min = 0, load_day = 0, load_month = 0, load_year = 0;
  logic btn_view = 0, btn_slow = 0, btn_fast = 0;
  logic [2:0] view;
  logic [23:0] digits;
  logic [5:0] blank;
  logic alarm_on, alarm_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selfset_clock #(.DEBOUNCE_CYCLES(DEB), .MAINS_DIV(50), .TONE_HALF(2), .BEEP_HALF(16)) uut (
    .clk(clk), .rst(rst), .locked(locked), .data_valid(data_valid),
    .sec_strobe(sec_strobe), .mains_tick(mains_tick),
    .load_hour(load_hour), .load_min(load_min), .load_day(load_day),
    .load_month(load_month), .load_year(load_year),
    .btn_view(btn_view), .btn_slow(btn_slow), .btn_fast(btn_fast),
    .view(view), .digits(digits), .blank(blank),
    .alarm_on(alarm_on), .alarm_out(alarm_out));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic strobe(input logic valid);
    @(negedge clk); sec_strobe = 1; data_valid = valid;
    @(negedge clk); sec_strobe = 0; data_valid = 0;
  endtask

  task automatic mains(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mains_tick = 1;
      @(negedge clk); mains_tick = 0;
    end
  endtask

  task automatic press(input int which, input int hold);
    @(negedge clk);
    case (which) 0: btn_view = 1; 1: btn_slow = 1; default: btn_fast = 1; endcase
    repeat (hold) @(negedge clk);
    btn_view = 0; btn_slow = 0; btn_fast = 0;
    repeat (DEB + 6) @(negedge clk);
  endtask

  task automatic preset(input logic [7:0] h, input logic [7:0] m);
    load_hour = h; load_min = m; load_day = 8'h05; load_month = 8'h03; load_year = 8'h91;
    strobe(1); settle();
  endtask

  task automatic t_reset();
    check("R3 reset time", digits, 24'h000000);
    check("R9 reset blank", blank, 6'b100000);
    check("R6 reset view", view, 3'b001);
    check("R11 reset alarm_on", alarm_on, 0);
  endtask

  task automatic t_preset_and_wrap();
    locked = 1;
    preset(8'h23, 8'h59);
    check("R1 preset time", digits, 24'h235900);
    check("R9 tens hour nonzero", blank, 6'b000000);
    for (int i = 0; i < 59; i++) strobe(0);
    settle();
    check("R2 seconds 59", digits, 24'h235959);
    strobe(0); settle();
    check("R3 midnight wrap", digits, 24'h000000);
    check("R9 zero tens hour blanked", blank, 6'b100000);
    for (int i = 0; i < 10; i++) strobe(0);
    settle();
    check("R2 units carry", digits, 24'h000010);
  endtask

  task automatic t_sources();
    mains(60); settle();
    check("R4 mains ignored while locked", digits, 24'h000010);
    locked = 0;
    settle();
    mains(49); settle();
    check("R5 49 ticks no advance", digits, 24'h000010);
    mains(1); settle();
    check("R5 50th tick advances", digits, 24'h000011);
    strobe(0); settle();
    check("R5 strobe ignored unlocked", digits, 24'h000011);
    locked = 1;
    settle();
    strobe(0); settle();
    check("R4 locked strobe advances", digits, 24'h000012);
  endtask

  task automatic t_views();
    press(0, 1);
    check("R7 short blip ignored", view, 3'b001);
    press(0, DEB + 6);
    check("R6 step to date", view, 3'b010);
    check("R8 date digits", digits, 24'h050391);
    check("R9 tens month blanked only", blank, 6'b001000);
    press(1, DEB + 6);
    press(2, DEB + 6);
    press(0, DEB + 6);
    check("R6 step to alarm", view, 3'b100);
    check("R10 keys ignored outside alarm view", digits, 24'h063000);
    check("R8 alarm blank mask", blank, 6'b100011);
    press(1, DEB + 6);
    check("R10 slow steps minute", digits, 24'h063100);
    press(2, DEB + 6);
    check("R10 fast steps hour", digits, 24'h073100);
    press(0, DEB + 6);
    check("R6 ring wraps to time", view, 3'b001);
    press(2, DEB + 6);
    press(0, DEB + 6);
    press(0, DEB + 6);
    check("R10 fast ignored in time view", digits, 24'h073100);
  endtask

  task automatic count_tone(output int ones);
    ones = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      if (alarm_out) ones++;
    end
  endtask

  task automatic t_alarm();
    int ones;
    count_tone(ones);
    check("R12 silent while idle", ones, 0);
    preset(8'h07, 8'h31);
    check("R11 full match sets", alarm_on, 1);
    count_tone(ones);
    check("R12 tone present", (ones > 0 && ones < 64) ? 1 : 0, 1);
    preset(8'h07, 8'h45);
    check("R11 holds on mismatch", alarm_on, 1);
    preset(8'h08, 8'h31);
    check("R11 minute-only match clears", alarm_on, 0);
    count_tone(ones);
    check("R12 silent after clear", ones, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    settle();
    t_reset();
    t_preset_and_wrap();
    t_sources();
    t_views();
    t_alarm();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule